// File: doc/BRIEF.md
# Flag Offset Register Load Sequencer

This block keeps the two threshold offsets that a FIFO's partial flags compare against: an almost-empty distance `n` and an almost-full distance `m`. Each offset is split into an 8-bit low part and a narrower high part. That gives four small registers in all. Software or a controller reaches all four through one active-low load strobe, and no address is needed. While the strobe is low, every qualified write-clock edge stores the data input into the next register of a fixed cycle. The cycle runs empty-low, empty-high, full-low, full-high, and then starts again. Every qualified read-clock edge puts the next register of the same cycle on the data output.

The write side and the read side each have their own 2-bit position. A position is kept while the strobe is high. A partial update can therefore stop and later carry on from where it left off. The complete offsets are always present on `n_ofs` and `m_ofs`, and the flag logic uses them directly. Loading and readback must not be done in the same cycle. The offsets are expected to change only while the FIFO is idle.

Top module: `ofs_load_seq`

## Requirements
- R1: While `rst` is high at a clock edge, both offsets return to 7: the low parts load 7 and the high parts load 0. `dout` clears to 0, and both the write position and the read position return to empty-low (position 0).
- R2: A write-clock edge with `load_n`=0 and `wen1_n`=0 stores `din` into the register at the write position. The positions are 0 = empty-low (`din[7:0]` becomes `n_ofs[7:0]`), 1 = empty-high (`din[HI_W-1:0]` becomes `n_ofs[OFS_W-1:8]`), 2 = full-low (`m_ofs[7:0]`) and 3 = full-high (`m_ofs[OFS_W-1:8]`). The position then steps by one.
- R3: A load write at position 3 (full-high) is followed by position 0, so a fifth consecutive write lands in empty-low again.
- R4: A write-clock edge with `load_n`=1 or `wen1_n`=1 leaves all four registers and the write position unchanged.
- R5: If `load_n` goes high after only some registers have been written, the next load write goes to the register that follows the last one written, not to empty-low.
- R6: A read-clock edge with `load_n`=0, `ren1_n`=0 and `ren2_n`=0 loads `dout` with the register at the read position, zero-extended to `DATA_W` bits. The read position then steps through the same order 0,1,2,3,0.
- R7: A read-clock edge with `load_n`=1, `ren1_n`=1 or `ren2_n`=1 leaves `dout` and the read position unchanged.
- R8: The write position and the read position advance independently. Writes never move the read position, and reads never move the write position.
- R9: `n_ofs` is {empty-high, empty-low} and `m_ofs` is {full-high, full-low}. Both change only on a write-clock edge that performs a load write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| load_n | input | 1 | Active-low offset access strobe |
| wen1_n | input | 1 | Active-low write enable |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| din | input | DATA_W | Data input; low bits are stored into the selected offset register |
| dout | output | DATA_W | Registered readback of the selected offset register |
| n_ofs | output | 8+HI_W | Combined almost-empty offset |
| m_ofs | output | 8+HI_W | Combined almost-full offset |

## Verification
The hardest state to reach is a write position that sits mid-cycle while the read position sits somewhere else. Readback and resumed loading are then both checked against a register other than empty-low. The stimulus builds this in steps. It writes part of the cycle and raises the strobe. It then reads a different number of registers, resumes writing, and wraps past full-high. After that it runs a long seeded random phase of strobes and enables, with simultaneous load write and readback excluded. A second reset in mid-sequence confirms that both positions and both offsets return to their reset values.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int LO_W     = 8;
    localparam int DFLT_OFS = 7;

    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } ofs_acc_t;

    function automatic ofs_sel_e sel_next(input ofs_sel_e s);
        logic [1:0] v;
        v = s + 2'd1;
        return ofs_sel_e'(v);
    endfunction

endpackage

// File: rtl/ofs_sel_ctr.sv
module ofs_sel_ctr
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output ofs_sel_e sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_E_LO;
        end else if (adv) begin
            sel <= sel_next(sel);
        end
    end

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int HI_W   = 6,
    localparam int OFS_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  ofs_sel_e          sel,
    input  logic [DATA_W-1:0] din,
    output logic [OFS_W-1:0]  n_ofs,
    output logic [OFS_W-1:0]  m_ofs
);

    logic [OFS_W-1:0] ofs_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_ofs
        localparam logic [1:0] LO_CODE = 2'(2 * g);
        localparam logic [1:0] HI_CODE = 2'(2 * g + 1);

        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= LO_W'(DFLT_OFS);
                hi_q <= '0;
            end else if (we) begin
                if (sel == LO_CODE) lo_q <= din[LO_W-1:0];
                if (sel == HI_CODE) hi_q <= din[HI_W-1:0];
            end
        end

        assign ofs_q[g] = {hi_q, lo_q};
    end

    assign n_ofs = ofs_q[0];
    assign m_ofs = ofs_q[1];

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int HI_W   = 6,
    localparam int OFS_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  ofs_sel_e          sel,
    input  logic [OFS_W-1:0]  n_ofs,
    input  logic [OFS_W-1:0]  m_ofs,
    output logic [DATA_W-1:0] dout
);

    logic [LO_W-1:0] part;

    always_comb begin
        unique case (sel)
            SEL_E_LO: part = n_ofs[LO_W-1:0];
            SEL_E_HI: part = LO_W'(n_ofs[OFS_W-1:LO_W]);
            SEL_F_LO: part = m_ofs[LO_W-1:0];
            default:  part = LO_W'(m_ofs[OFS_W-1:LO_W]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd) begin
            dout <= DATA_W'(part);
        end
    end

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int HI_W   = 6,
    localparam int OFS_W = LO_W + HI_W
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OFS_W-1:0]  n_ofs,
    output logic [OFS_W-1:0]  m_ofs
);

    ofs_acc_t acc;
    ofs_sel_e wsel;
    ofs_sel_e rsel;

    always_comb begin
        acc.wr = !load_n && !wen1_n;
        acc.rd = !load_n && !ren1_n && !ren2_n;
    end

    ofs_sel_ctr i_wsel (
        .clk (wclk),
        .rst (rst),
        .adv (acc.wr),
        .sel (wsel)
    );

    ofs_sel_ctr i_rsel (
        .clk (rclk),
        .rst (rst),
        .adv (acc.rd),
        .sel (rsel)
    );

    ofs_reg_bank #(.DATA_W(DATA_W), .HI_W(HI_W)) i_bank (
        .clk   (wclk),
        .rst   (rst),
        .we    (acc.wr),
        .sel   (wsel),
        .din   (din),
        .n_ofs (n_ofs),
        .m_ofs (m_ofs)
    );

    ofs_readback #(.DATA_W(DATA_W), .HI_W(HI_W)) i_rdbk (
        .clk   (rclk),
        .rst   (rst),
        .rd    (acc.rd),
        .sel   (rsel),
        .n_ofs (n_ofs),
        .m_ofs (m_ofs),
        .dout  (dout)
    );

endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int HI_W   = 6,
    localparam int OFS_W = LO_W + HI_W
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst,
    input logic              load_n,
    input logic              wen1_n,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic [OFS_W-1:0]  n_ofs,
    input logic [OFS_W-1:0]  m_ofs,
    input logic [1:0]        wsel,
    input logic [1:0]        rsel
);

    logic wr;
    logic rd;
    assign wr = !load_n && !wen1_n;
    assign rd = !load_n && !ren1_n && !ren2_n;

    a_r2_store_elo: assert property (@(posedge wclk) disable iff (rst)
        (wr && wsel == 2'd0) |=> n_ofs[LO_W-1:0] == $past(din[LO_W-1:0]));

    a_r2_store_fhi: assert property (@(posedge wclk) disable iff (rst)
        (wr && wsel == 2'd3) |=> m_ofs[OFS_W-1:LO_W] == $past(din[HI_W-1:0]));

    a_r3_wrap: assert property (@(posedge wclk) disable iff (rst)
        (wr && wsel == 2'd3) |=> wsel == 2'd0);

    a_r4_sel_hold: assert property (@(posedge wclk) disable iff (rst)
        !wr |=> $stable(wsel));

    a_r9_ofs_stable: assert property (@(posedge wclk) disable iff (rst)
        !wr |=> ($stable(n_ofs) && $stable(m_ofs)));

    a_r7_dout_hold: assert property (@(posedge rclk) disable iff (rst)
        !rd |=> ($stable(dout) && $stable(rsel)));

    a_r6_upper_zero: assert property (@(posedge rclk) disable iff (rst)
        rd |=> dout[DATA_W-1:LO_W] == '0);

endmodule

bind ofs_load_seq ofs_load_seq_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) i_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .rst    (rst),
    .load_n (load_n),
    .wen1_n (wen1_n),
    .ren1_n (ren1_n),
    .ren2_n (ren2_n),
    .din    (din),
    .dout   (dout),
    .n_ofs  (n_ofs),
    .m_ofs  (m_ofs),
    .wsel   (wsel),
    .rsel   (rsel)
);

// File: tb/test_ofs_load_seq.sv
module test_ofs_load_seq;

    localparam int DATA_W = 9;
    localparam int HI_W   = 6;
    localparam int OFS_W  = 8 + HI_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              load_n, wen1_n, ren1_n, ren2_n;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;
    logic [OFS_W-1:0]  n_ofs, m_ofs;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_lo [2];
    logic [HI_W-1:0] m_hi [2];
    logic [1:0]  m_wsel, m_rsel;
    logic [DATA_W-1:0] m_dout;

    always #10 clk = ~clk;

    ofs_load_seq #(.DATA_W(DATA_W), .HI_W(HI_W)) i_ofs_load_seq (
        .wclk (clk), .rclk (clk), .rst (rst),
        .load_n (load_n), .wen1_n (wen1_n), .ren1_n (ren1_n), .ren2_n (ren2_n),
        .din (din), .dout (dout), .n_ofs (n_ofs), .m_ofs (m_ofs)
    );

    function automatic logic [DATA_W-1:0] exp_part(input logic [1:0] s);
        logic [7:0] p;
        p = s[0] ? 8'(m_hi[s[1]]) : m_lo[s[1]];
        return DATA_W'(p);
    endfunction

    function automatic logic [OFS_W-1:0] exp_ofs(input int i);
        return {m_hi[i], m_lo[i]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = 8'd7;
            m_hi[i] = '0;
        end
        m_wsel = 2'd0;
        m_rsel = 2'd0;
        m_dout = '0;
    endtask

    // One cycle: inputs driven at the falling edge, model stepped at the
    // rising edge, outputs compared 5 ns after it.
    task automatic cyc(input logic r, input logic ld, input logic w1,
                       input logic r1, input logic r2,
                       input logic [DATA_W-1:0] d, input string req);
        rst = r; load_n = ld; wen1_n = w1; ren1_n = r1; ren2_n = r2; din = d;
        @(posedge clk);
        if (r) begin
            model_reset();
        end else begin
            if (!ld && !r1 && !r2) begin
                m_dout = exp_part(m_rsel);
                m_rsel = m_rsel + 2'd1;
            end
            if (!ld && !w1) begin
                if (m_wsel[0]) m_hi[m_wsel[1]] = d[HI_W-1:0];
                else           m_lo[m_wsel[1]] = d[7:0];
                m_wsel = m_wsel + 2'd1;
            end
        end
        #5;
        chk(req, "n_ofs", 32'(n_ofs), 32'(exp_ofs(0)));
        chk(req, "m_ofs", 32'(m_ofs), 32'(exp_ofs(1)));
        chk(req, "dout", 32'(dout), 32'(m_dout));
        @(negedge clk);
    endtask

    task automatic wr(input logic [DATA_W-1:0] d, input string req);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, d, req);
    endtask

    task automatic rd(input string req);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h1AA, req);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic l, w, a, b;
        seed = $urandom(32'd4711);
        model_reset();
        rst = 1'b1; load_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; din = '0;
        @(negedge clk);
        // R1: reset values
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, "R1");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, "R1");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, "R1");
        // R2: empty-low, empty-high, full-low in order
        wr(9'h1C3, "R2");
        wr(9'h1F5, "R2");
        wr(9'h05A, "R2");
        // R4: strobe high with enable low, then enable high with strobe low
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 9'h0FF, "R4");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 9'h0EE, "R4");
        // R5: resume at full-high
        wr(9'h03C, "R5");
        // R3: fifth write wraps to empty-low
        wr(9'h111, "R3");
        wr(9'h022, "R3");
        // R6: readback of all four and the wrap
        for (int i = 0; i < 5; i++) rd("R6");
        // R7: one read enable or the strobe inactive
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R7");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R7");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7");
        rd("R7");
        // R8: interleaved writes and reads at different positions
        wr(9'h0A5, "R8");
        rd("R8");
        wr(9'h1FE, "R8");
        wr(9'h07E, "R8");
        rd("R8");
        rd("R8");
        // R9: random strobes and enables, no simultaneous load write and read
        for (int i = 0; i < 600; i++) begin
            l = ($urandom % 4) == 0;
            w = $urandom % 2;
            a = $urandom % 2;
            b = ($urandom % 4) == 0;
            if (!l && !w) a = 1'b1;
            cyc(1'b0, l, w, a, b, DATA_W'($urandom), "R9");
        end
        // R1: reset in the middle of a sequence
        wr(9'h033, "R1");
        rd("R1");
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h044, "R1");
        rd("R1");
        wr(9'h066, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule